// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block times the serial clock of an I2C master. A prescaler divides the functional clock down to an internal timing clock. Two programmable count registers then set the length of the low half and of the high half of every SCL period, each phase lasting its count plus a fixed offset of six steps. Each count register carries two fields. The lower byte times standard and fast-mode phases in internal-clock steps. The upper byte times high-speed phases in steps of the undivided functional clock.

The protocol engine asks for clocking with `run`. It selects high-speed operation with `hs_enable`, which corresponds to the mode bit at position 12 of its configuration word. With `hs_phase` it marks that the fast-mode preamble is over and the high-speed counts now apply. The generator drives SCL low during the low phase and releases it during the high phase. It watches the line through a two-stage synchroniser and freezes the high-phase count while another device holds SCL low. A one-cycle strobe marks each falling and each rising phase edge. With `enable` low, everything is held cleared.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset and while `run` is 0, `scl_drive_low`, `fall_stb`, `rise_stb` and `scl_held` are all 0.
- R2: When `run` is 1 in the idle state, the low phase comes first. From the next cycle `scl_drive_low` is 1 and `fall_stb` is 1 for that one cycle.
- R3: A fast-mode low phase lasts (low_cfg[7:0] + 6) × (prescale + 1) clock cycles.
- R4: A fast-mode high phase lasts (high_cfg[7:0] + 6) × (prescale + 1) counted cycles. A cycle counts only when the synchronised SCL reads high. With the line otherwise free, this adds 2 cycles of synchroniser latency.
- R5: A phase that starts while `hs_enable` and `hs_phase` are both 1 uses bits 15:8 of its count register and counts every clock cycle. A low phase then lasts field + 6 cycles, and a high phase lasts field + 6 counted cycles. `prescale` has no effect on such a phase.
- R6: With `hs_enable` = 1 and `hs_phase` = 0, or with `hs_enable` = 0 whatever `hs_phase` is, phases use the fast-mode timing of R3 and R4.
- R7: Each cycle in which an external device holds SCL low during a high phase lengthens that phase by one cycle. `scl_held` is 1 exactly in the held cycles, the 2 synchroniser cycles included.
- R8: `rise_stb` pulses for one cycle when a high phase begins, with `scl_drive_low` 0. `fall_stb` and `rise_stb` are never 1 together.
- R9: At the end of a high phase, if `run` is 1, the next low phase starts at once with `fall_stb`. If `run` is 0, the block goes idle with SCL released and no strobe.
- R10: `enable` = 0 clears the block in the next cycle: SCL is released, no strobes, and `run` is ignored. After `enable` returns to 1, clocking restarts from the idle state with a low phase.
- R11: The count and the mode of a phase are sampled when the phase starts. Changing `low_cfg` during a phase has no effect on that phase and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 holds everything cleared |
| prescale | input | PSC_W | Divider: internal clock = clk / (prescale + 1) |
| low_cfg | input | 2*CNT_W | Low-phase counts: [7:0] fast mode, [15:8] high speed |
| high_cfg | input | 2*CNT_W | High-phase counts: [7:0] fast mode, [15:8] high speed |
| hs_enable | input | 1 | High-speed mode selected |
| hs_phase | input | 1 | Preamble done, high-speed counts apply |
| run | input | 1 | Protocol engine requests SCL clocking |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | One-cycle strobe at the start of a low phase |
| rise_stb | output | 1 | One-cycle strobe at the start of a high phase |
| scl_held | output | 1 | High-phase count frozen because SCL reads low |

## Verification
Directed pairs with prescale 1 and small counts check the basic relation between counts and durations. High-speed cases use upper and lower bytes that differ, so selecting the wrong byte or applying the divider shows up as a wrong length. The two partial mode combinations (mode bit without phase, phase without mode bit) separate R5 from R6. A random sweep over prescale, both count fields, both mode inputs and stretch widths of 0 to 3 cycles covers the rest. Each low and high length is compared with its formula. That sweep tells a lost stretch cycle from an off-by-one in the offset. Mid-phase register changes and an enable drop in the middle of a low phase cover sampling and clearing.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sync_d[g] = din;
        end else begin : g_next
            assign sync_d[g] = sync_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q >= div);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)        cnt_d = '0;
        else if (hold)  cnt_d = cnt_q;
        else if (tick)  cnt_d = '0;
        else            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !hold && div != '0) |=> (!tick || div == '0)); // R3
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int CNT_W       = 8,
    parameter int OFFSET      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [PSC_W-1:0]   prescale,
    input  logic [2*CNT_W-1:0] low_cfg,
    input  logic [2*CNT_W-1:0] high_cfg,
    input  logic               hs_enable,
    input  logic               hs_phase,
    input  logic               run,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               fall_stb,
    output logic               rise_stb,
    output logic               scl_held
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] LOAD_ADJ = CW'(OFFSET - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          hs;
        logic          fall;
        logic          rise;
    } gen_state_t;

    localparam gen_state_t RESET_STATE = '{ph: PH_IDLE, cnt: '0, hs: 1'b0,
                                           fall: 1'b0, rise: 1'b0};

    gen_state_t r_d, r_q;
    logic       scl_seen;
    logic       tick;
    logic       held;
    logic       step;
    logic       hs_now;

    function automatic logic [CW-1:0] load_count(input logic [2*CNT_W-1:0] cfg,
                                                 input logic hs);
        if (hs) return {1'b0, cfg[2*CNT_W-1:CNT_W]} + LOAD_ADJ;
        else    return {1'b0, cfg[CNT_W-1:0]} + LOAD_ADJ;
    endfunction

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .dout  (scl_seen)
    );

    assign held   = enable && (r_q.ph == PH_HIGH) && !scl_seen;
    assign hs_now = hs_enable && hs_phase;

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable || (r_q.ph == PH_IDLE) || r_q.hs),
        .hold  (held),
        .div   (prescale),
        .tick  (tick)
    );

    assign step = (r_q.hs || tick) && !held;

    always_comb begin
        r_d      = r_q;
        r_d.fall = 1'b0;
        r_d.rise = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (run) begin
                    r_d.ph   = PH_LOW;
                    r_d.hs   = hs_now;
                    r_d.cnt  = load_count(low_cfg, hs_now);
                    r_d.fall = 1'b1;
                end
            end
            PH_LOW: begin
                if (step) begin
                    if (r_q.cnt == '0) begin
                        r_d.ph   = PH_HIGH;
                        r_d.hs   = hs_now;
                        r_d.cnt  = load_count(high_cfg, hs_now);
                        r_d.rise = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
            end
            PH_HIGH: begin
                if (step) begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else if (run) begin
                        r_d.ph   = PH_LOW;
                        r_d.hs   = hs_now;
                        r_d.cnt  = load_count(low_cfg, hs_now);
                        r_d.fall = 1'b1;
                    end else begin
                        r_d.ph  = PH_IDLE;
                        r_d.hs  = 1'b0;
                        r_d.cnt = '0;
                    end
                end
            end
            default: r_d = RESET_STATE;
        endcase
        if (!enable) r_d = RESET_STATE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_STATE;
        else        r_q <= r_d;
    end

    assign scl_drive_low = (r_q.ph == PH_LOW);
    assign fall_stb      = r_q.fall;
    assign rise_stb      = r_q.rise;
    assign scl_held      = held;

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb)); // R8
    AST_FALL_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_drive_low); // R2
    AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> !scl_drive_low); // R8
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        scl_held |=> $stable(r_q.cnt)); // R7
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !fall_stb && !rise_stb)); // R10
    AST_LOW_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && enable) |=> scl_drive_low); // R3
endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n, enable, hs_enable, hs_phase, run, stretch;
    logic [7:0]  prescale;
    logic [15:0] low_cfg, high_cfg;
    logic        scl_drive_low, fall_stb, rise_stb, scl_held;
    logic        scl_line;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    assign scl_line = !scl_drive_low && !stretch;

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .low_cfg(low_cfg), .high_cfg(high_cfg), .hs_enable(hs_enable),
        .hs_phase(hs_phase), .run(run), .scl_in(scl_line),
        .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
        .rise_stb(rise_stb), .scl_held(scl_held)
    );

    function automatic int exp_len(input logic [15:0] cfg, input int psc, input bit hs);
        if (hs) return int'(cfg[15:8]) + 6;
        return (int'(cfg[7:0]) + 6) * (psc + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one low + high period with optional stretch, then a return to idle
    task automatic pair(input int w, input string tag);
        int lo, hi, hd, wl, elo, ehi;
        bit hs, bad;
        hs  = hs_enable && hs_phase;
        elo = exp_len(low_cfg, prescale, hs);
        ehi = exp_len(high_cfg, prescale, hs);
        run = 1'b1;
        @(negedge clk);
        chk(scl_drive_low && fall_stb, "R2 low first with fall strobe", {scl_drive_low, fall_stb}, 3);
        lo = 0;
        while (scl_drive_low) begin lo++; @(negedge clk); end
        chk(lo == elo, {tag, " low length"}, lo, elo);
        chk(rise_stb && !fall_stb, "R8 rise strobe", rise_stb, 1);
        stretch = (w > 0);
        wl = w; hi = 0; hd = 0;
        while (!scl_drive_low) begin
            hi++;
            if (scl_held) hd++;
            @(negedge clk);
            if (wl > 0) begin wl--; if (wl == 0) stretch = 1'b0; end
        end
        chk(hi == ehi + 2 + w, {tag, " high length (R4/R7)"}, hi, ehi + 2 + w);
        chk(hd == 2 + w, "R7 held cycles", hd, 2 + w);
        chk(fall_stb, "R9 back-to-back low", fall_stb, 1);
        run = 1'b0;
        while (scl_drive_low) @(negedge clk);
        bad = 0;
        repeat (ehi + 12) begin
            if (scl_drive_low || fall_stb) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R9 idle after run drops", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo, lo2;
        void'($urandom(32'd4242));
        rst_n = 0; enable = 0; hs_enable = 0; hs_phase = 0; run = 0; stretch = 0;
        prescale = 8'd1; low_cfg = 16'h0004; high_cfg = 16'h0002;
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !fall_stb && !rise_stb && !scl_held, "R1 reset", scl_drive_low, 0);
        rst_n = 1; enable = 1;
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !fall_stb && !rise_stb && !scl_held, "R1 idle", scl_drive_low, 0);

        pair(0, "R3");
        prescale = 8'd3; low_cfg = 16'h0701; high_cfg = 16'h0903;
        pair(0, "R3");
        hs_enable = 1; hs_phase = 1; prescale = 8'd2;
        low_cfg = 16'h0305; high_cfg = 16'h0A01;
        pair(0, "R5");
        pair(3, "R5");
        hs_phase = 0;
        pair(0, "R6");
        hs_enable = 0; hs_phase = 1;
        pair(0, "R6");
        hs_phase = 0; prescale = 8'd0;
        pair(4, "R7");

        // R11: count change during a low phase applies to the next one
        prescale = 8'd0; low_cfg = 16'h000A; high_cfg = 16'h0000;
        run = 1;
        @(negedge clk);
        lo = 0;
        while (scl_drive_low) begin
            lo++;
            if (lo == 3) low_cfg = 16'h0000;
            @(negedge clk);
        end
        chk(lo == 16, "R11 current phase keeps old count", lo, 16);
        while (!scl_drive_low) @(negedge clk);
        run = 0;
        lo2 = 0;
        while (scl_drive_low) begin lo2++; @(negedge clk); end
        chk(lo2 == 6, "R11 next phase uses new count", lo2, 6);
        repeat (30) @(negedge clk);

        // R10: enable drop mid-phase
        low_cfg = 16'h0008; high_cfg = 16'h0002; run = 1;
        repeat (4) @(negedge clk);
        enable = 0;
        @(negedge clk);
        chk(!scl_drive_low && !fall_stb && !rise_stb, "R10 cleared", scl_drive_low, 0);
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !fall_stb, "R10 run ignored", scl_drive_low, 0);
        enable = 1;
        @(negedge clk);
        chk(scl_drive_low && fall_stb, "R10 restart with low", {scl_drive_low, fall_stb}, 3);
        run = 0;
        repeat (60) @(negedge clk);

        for (int i = 0; i < 40; i++) begin
            prescale  = 8'($urandom % 4);
            low_cfg   = {8'($urandom % 12), 8'($urandom % 20)};
            high_cfg  = {8'($urandom % 12), 8'($urandom % 20)};
            hs_enable = 1'($urandom % 2);
            hs_phase  = 1'($urandom % 2);
            pair(int'($urandom % 4), (hs_enable && hs_phase) ? "R5" : "R6");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule